// File: doc/BRIEF.md
# Software Interrupt Source Tracker

This block keeps the pending state of the sixteen software-raised interrupt numbers in a cluster of up to eight processors. A processor raises one of these interrupts with a single 32-bit command word. The word names the interrupt number and a rule that picks the receiving processors. For every interrupt number and every receiving processor, the block keeps a bitmap with one bit per sending processor. A receiver can therefore tell who raised the interrupt, even when several senders raised the same number before the receiver took it.

A receiver acknowledges one interrupt number at a time. In the same cycle, the block returns a word that holds the number and the index of one sender, lowest index first. On the next clock edge, that sender's bit is removed. The pending flag drops only when no sender bits remain. Byte-wide set and clear operations let a processor edit its own sender bitmap for one number directly. Priority arbitration is left to the surrounding interrupt logic, which reads one pending flag per processor and per number.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset, every bit of `pendOut` is 0, and an acknowledge of any number returns 1023.
- R2: A command with `cmdData[25:24]` = 0 uses `cmdData[23:16]` as the receiver list. List bits at or above NUM_CPU are dropped. The interrupt number is `cmdData[3:0]`. Each receiver sets the sender's bit in its bitmap for that number and raises `pendOut[receiver*16 + number]`.
- R3: With `cmdData[25:24]` = 1, the receivers are all processors below NUM_CPU except the sender.
- R4: With `cmdData[25:24]` = 2, the only receiver is the sender itself.
- R5: With `cmdData[25:24]` = 3, the command changes no state.
- R6: A command with `cmdFull` = 0 (a narrower than 32-bit write) changes no state.
- R7: An acknowledge of a non-empty bitmap returns, in the same cycle, `ackWord` = (lowest set sender index << 10) | number. Bits [9:4] are zero. At the next clock edge, that sender's bit is cleared.
- R8: The pending flag stays 1 while any sender bit remains after an acknowledge. It falls to 0 when the bitmap becomes empty.
- R9: An acknowledge of an empty bitmap returns 1023 and changes no state.
- R10: A byte clear (`byteSet` = 0) removes `byteBits` from the requester's own bitmap for `byteId`. Pending falls if that bitmap becomes empty.
- R11: A byte set (`byteSet` = 1) ORs `byteBits` (masked to NUM_CPU) into the requester's own bitmap for `byteId`. It raises pending even when the written bits are zero.
- R12: A command, byte operation or acknowledge whose processor index is NUM_CPU or above changes no state, and such an acknowledge returns 1023.
- R13: Operations on the three channels in the same cycle are merged per bitmap. A bit that is both set and cleared ends set, and any set raises pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdValid | input | 1 | Dispatch command strobe |
| cmdCpu | input | 3 | Index of the processor sending the command |
| cmdFull | input | 1 | 1 when the command is a full 32-bit write |
| cmdData | input | 32 | Command word: filter [25:24], receiver list [23:16], number [3:0] |
| byteValid | input | 1 | Byte bitmap operation strobe |
| byteCpu | input | 3 | Requesting processor; its own bitmap is edited |
| byteSet | input | 1 | 1 = OR bits in, 0 = remove bits |
| byteId | input | 4 | Interrupt number of the edited bitmap |
| byteBits | input | 8 | Sender bits to set or clear |
| ackValid | input | 1 | Acknowledge strobe |
| ackCpu | input | 3 | Acknowledging processor |
| ackId | input | 4 | Interrupt number being acknowledged |
| ackWord | output | 13 | Acknowledge result: sender [12:10], number [3:0], or 1023 |
| pendOut | output | NUM_CPU*16 | Pending flag, bit receiver*16 + number |

## Verification
The checker watches every cycle for the following:
- A pending flag that falls without an acknowledge or byte clear in the previous cycle.
- A non-spurious acknowledge word with a bad field layout or an out-of-range sender.
- State changes after an invalid filter, a narrow command or an empty acknowledge.
- A self-targeted command that fails to raise its flag.

Three behaviours depend on bitmap contents hidden behind the ports, so only the bench scenarios can show them:
- the lowest-first service order across several senders;
- pending that holds until the last sender is taken;
- the merge of a same-cycle set and clear on one bit.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int SGI_COUNT = 16;
  localparam int SGI_ID_W  = 4;
  localparam int CPU_MAX   = 8;
  localparam int CPU_IDX_W = 3;
  localparam int ACK_W     = 13;
  localparam logic [ACK_W-1:0] SPURIOUS = 13'd1023;

  typedef enum logic [1:0] {
    FILT_LIST   = 2'd0,
    FILT_OTHERS = 2'd1,
    FILT_SELF   = 2'd2,
    FILT_BAD    = 2'd3
  } filtT;

  typedef struct packed {
    logic                 dispEn;
    logic [SGI_ID_W-1:0]  dispId;
    logic [CPU_MAX-1:0]   dispTgt;   // receivers of the command
    logic [CPU_MAX-1:0]   dispSrc;   // one-hot sender bit
    logic                 byteEn;
    logic                 byteSet;
    logic [SGI_ID_W-1:0]  byteId;
    logic [CPU_MAX-1:0]   byteRow;   // one-hot row being edited
    logic [CPU_MAX-1:0]   byteBits;
    logic                 ackEn;
    logic [SGI_ID_W-1:0]  ackId;
    logic [CPU_MAX-1:0]   ackRow;    // one-hot acknowledging row
    logic [CPU_MAX-1:0]   ackBit;    // one-hot sender bit to drop
  } sgiStrobeT;
endpackage

// File: rtl/sgi_ctrl.sv
module sgi_ctrl
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8
) (
  input  logic                 cmdValid,
  input  logic [CPU_IDX_W-1:0] cmdCpu,
  input  logic                 cmdFull,
  input  logic [31:0]          cmdData,
  input  logic                 byteValid,
  input  logic [CPU_IDX_W-1:0] byteCpu,
  input  logic                 byteSet,
  input  logic [SGI_ID_W-1:0]  byteId,
  input  logic [7:0]           byteBits,
  input  logic                 ackValid,
  input  logic [CPU_IDX_W-1:0] ackCpu,
  input  logic [SGI_ID_W-1:0]  ackId,
  input  logic [CPU_MAX-1:0]   ackRowBits,
  output sgiStrobeT            strb,
  output logic [ACK_W-1:0]     ackWord
);
  localparam logic [CPU_IDX_W:0] CPU_LIMIT = (CPU_IDX_W+1)'(NUM_CPU);
  localparam logic [CPU_MAX-1:0] CPU_MASK  = CPU_MAX'((1 << NUM_CPU) - 1);

  logic cmdCpuOk, byteCpuOk, ackCpuOk;
  logic [CPU_MAX-1:0] cmdSelf;
  logic [CPU_MAX-1:0] tgt;
  filtT filt;
  logic [CPU_IDX_W-1:0] srcIdx;
  logic ackLive;
  logic unusedBits;

  assign cmdCpuOk  = {1'b0, cmdCpu}  < CPU_LIMIT;
  assign byteCpuOk = {1'b0, byteCpu} < CPU_LIMIT;
  assign ackCpuOk  = {1'b0, ackCpu}  < CPU_LIMIT;
  assign cmdSelf   = CPU_MAX'(1) << cmdCpu;
  assign filt      = filtT'(cmdData[25:24]);
  assign unusedBits = ^{cmdData[31:26], cmdData[15:4]};

  always_comb begin
    unique case (filt)
      FILT_LIST:   tgt = cmdData[23:16] & CPU_MASK;
      FILT_OTHERS: tgt = CPU_MASK & ~cmdSelf;
      FILT_SELF:   tgt = cmdSelf;
      default:     tgt = '0;
    endcase
  end

  // lowest set sender wins
  always_comb begin
    srcIdx = '0;
    for (int i = CPU_MAX - 1; i >= 0; i--) begin
      if (ackRowBits[i]) srcIdx = CPU_IDX_W'(i);
    end
  end

  assign ackLive = ackValid && ackCpuOk && (ackRowBits != '0);
  assign ackWord = ackLive ? {srcIdx, 6'b000000, ackId} : SPURIOUS;

  always_comb begin
    strb          = '0;
    strb.dispEn   = cmdValid && cmdFull && cmdCpuOk && (filt != FILT_BAD);
    strb.dispId   = cmdData[3:0];
    strb.dispTgt  = tgt;
    strb.dispSrc  = cmdSelf;
    strb.byteEn   = byteValid && byteCpuOk;
    strb.byteSet  = byteSet;
    strb.byteId   = byteId;
    strb.byteRow  = CPU_MAX'(1) << byteCpu;
    strb.byteBits = byteBits & CPU_MASK;
    strb.ackEn    = ackLive;
    strb.ackId    = ackId;
    strb.ackRow   = CPU_MAX'(1) << ackCpu;
    strb.ackBit   = CPU_MAX'(1) << srcIdx;
  end
endmodule

// File: rtl/sgi_store.sv
module sgi_store
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  sgiStrobeT                     strb,
  input  logic [CPU_IDX_W-1:0]          rdCpu,
  input  logic [SGI_ID_W-1:0]           rdId,
  output logic [CPU_MAX-1:0]            rdRow,
  output logic [NUM_CPU*SGI_COUNT-1:0]  pendOut
);
  localparam int CELLS = SGI_COUNT * NUM_CPU;
  localparam logic [CPU_MAX-1:0] CPU_MASK = CPU_MAX'((1 << NUM_CPU) - 1);

  logic [CELLS*CPU_MAX-1:0] mapFlat;

  for (genvar gi = 0; gi < SGI_COUNT; gi++) begin : g_id
    for (genvar gt = 0; gt < NUM_CPU; gt++) begin : g_cpu
      localparam logic [SGI_ID_W-1:0] ID_C = SGI_ID_W'(gi);
      logic [CPU_MAX-1:0] mapQ, setV, clrV, mapNext;
      logic pendQ, dispHit, bSetHit, bClrHit, ackHit;

      assign dispHit = strb.dispEn && (strb.dispId == ID_C) && strb.dispTgt[gt];
      assign bSetHit = strb.byteEn && strb.byteSet && (strb.byteId == ID_C) && strb.byteRow[gt];
      assign bClrHit = strb.byteEn && !strb.byteSet && (strb.byteId == ID_C) && strb.byteRow[gt];
      assign ackHit  = strb.ackEn && (strb.ackId == ID_C) && strb.ackRow[gt];

      assign setV = (dispHit ? strb.dispSrc : '0) | (bSetHit ? strb.byteBits : '0);
      assign clrV = (ackHit ? strb.ackBit : '0) | (bClrHit ? strb.byteBits : '0);
      assign mapNext = ((mapQ & ~clrV) | setV) & CPU_MASK;

      always_ff @(posedge clk) begin
        if (rst) begin
          mapQ  <= '0;
          pendQ <= 1'b0;
        end else begin
          mapQ <= mapNext;
          if (dispHit || bSetHit)
            pendQ <= 1'b1;
          else if ((ackHit || bClrHit) && (mapNext == '0))
            pendQ <= 1'b0;
        end
      end

      assign mapFlat[(gi*NUM_CPU + gt)*CPU_MAX +: CPU_MAX] = mapQ;
      assign pendOut[gt*SGI_COUNT + gi] = pendQ;
    end
  end

  always_comb begin
    rdRow = '0;
    for (int t = 0; t < NUM_CPU; t++) begin
      if (rdCpu == CPU_IDX_W'(t))
        rdRow = mapFlat[(int'(rdId)*NUM_CPU + t)*CPU_MAX +: CPU_MAX];
    end
  end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmdValid,
  input  logic [2:0]                   cmdCpu,
  input  logic                         cmdFull,
  input  logic [31:0]                  cmdData,
  input  logic                         byteValid,
  input  logic [2:0]                   byteCpu,
  input  logic                         byteSet,
  input  logic [3:0]                   byteId,
  input  logic [7:0]                   byteBits,
  input  logic                         ackValid,
  input  logic [2:0]                   ackCpu,
  input  logic [3:0]                   ackId,
  output logic [12:0]                  ackWord,
  output logic [NUM_CPU*16-1:0]        pendOut
);
  sgiStrobeT strb;
  logic [CPU_MAX-1:0] ackRowBits;

  sgi_ctrl #(.NUM_CPU(NUM_CPU)) u_ctrl (
    .cmdValid(cmdValid), .cmdCpu(cmdCpu), .cmdFull(cmdFull), .cmdData(cmdData),
    .byteValid(byteValid), .byteCpu(byteCpu), .byteSet(byteSet),
    .byteId(byteId), .byteBits(byteBits),
    .ackValid(ackValid), .ackCpu(ackCpu), .ackId(ackId),
    .ackRowBits(ackRowBits), .strb(strb), .ackWord(ackWord)
  );

  sgi_store #(.NUM_CPU(NUM_CPU)) u_store (
    .clk(clk), .rst(rst), .strb(strb),
    .rdCpu(ackCpu), .rdId(ackId), .rdRow(ackRowBits), .pendOut(pendOut)
  );
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NUM_CPU = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cmdValid,
  input logic [2:0]            cmdCpu,
  input logic                  cmdFull,
  input logic [31:0]           cmdData,
  input logic                  byteValid,
  input logic                  byteSet,
  input logic                  ackValid,
  input logic [2:0]            ackCpu,
  input logic [3:0]            ackId,
  input logic [12:0]           ackWord,
  input logic [NUM_CPU*16-1:0] pendOut
);
  localparam int PEND_W = NUM_CPU * 16;
  localparam logic [3:0] CPU_LIMIT = 4'(NUM_CPU);

  logic [PEND_W-1:0] selfHot;
  logic cmdCpuOk, quietOthers;
  assign selfHot     = PEND_W'(1) << {cmdCpu, cmdData[3:0]};
  assign cmdCpuOk    = {1'b0, cmdCpu} < CPU_LIMIT;
  assign quietOthers = !byteValid && !ackValid;

  // a flag may only fall after an acknowledge or a byte clear
  p_fall_needs_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (|($past(pendOut) & ~pendOut)) |-> $past(ackValid || (byteValid && !byteSet)));

  p_ack_fields_r7: assert property (@(posedge clk) disable iff (rst)
    (ackValid && ackWord != 13'd1023) |->
      (ackWord[9:4] == 6'd0 && ackWord[3:0] == ackId && {1'b0, ackWord[12:10]} < CPU_LIMIT));

  p_bad_filter_r5: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdData[25:24] == 2'd3 && quietOthers) |=> $stable(pendOut));

  p_narrow_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && !cmdFull && quietOthers) |=> $stable(pendOut));

  p_empty_ack_r9: assert property (@(posedge clk) disable iff (rst)
    (ackValid && ackWord == 13'd1023 && !cmdValid && !byteValid) |=> $stable(pendOut));

  p_self_raise_r4: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdFull && cmdData[25:24] == 2'd2 && cmdCpuOk) |=> |($past(selfHot) & pendOut));

  p_bad_ack_cpu_r12: assert property (@(posedge clk) disable iff (rst)
    (ackValid && {1'b0, ackCpu} >= CPU_LIMIT) |-> ackWord == 13'd1023);
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdCpu(cmdCpu), .cmdFull(cmdFull),
  .cmdData(cmdData), .byteValid(byteValid), .byteSet(byteSet),
  .ackValid(ackValid), .ackCpu(ackCpu), .ackId(ackId),
  .ackWord(ackWord), .pendOut(pendOut)
);

// File: tb/sgi_dispatch_tb.sv
`timescale 1ns/1ps
module sgi_dispatch_tb;
  localparam int NC = 4;
  localparam int PW = NC * 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmdValid = 0, cmdFull = 0, byteValid = 0, byteSet = 0, ackValid = 0;
  logic [2:0] cmdCpu = 0, byteCpu = 0, ackCpu = 0;
  logic [31:0] cmdData = 0;
  logic [3:0] byteId = 0, ackId = 0;
  logic [7:0] byteBits = 0;
  logic [12:0] ackWord;
  logic [PW-1:0] pendOut;

  int checks = 0;
  int failures = 0;
  logic [7:0] mMap [16][8];
  logic       mPend [16][8];

  always #10 clk = ~clk;

  sgi_dispatch #(.NUM_CPU(NC)) u_dut (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdCpu(cmdCpu), .cmdFull(cmdFull),
    .cmdData(cmdData), .byteValid(byteValid), .byteCpu(byteCpu), .byteSet(byteSet),
    .byteId(byteId), .byteBits(byteBits), .ackValid(ackValid), .ackCpu(ackCpu),
    .ackId(ackId), .ackWord(ackWord), .pendOut(pendOut)
  );

  function automatic logic [PW-1:0] expPend();
    logic [PW-1:0] v = '0;
    for (int t = 0; t < NC; t++)
      for (int i = 0; i < 16; i++) v[t*16 + i] = mPend[i][t];
    return v;
  endfunction

  function automatic logic [12:0] expAck(input logic [2:0] c, input logic [3:0] id);
    if (c >= NC || mMap[id][c] == 0) return 13'd1023;
    for (int s = 0; s < NC; s++)
      if (mMap[id][c][s]) return 13'(s * 1024 + int'(id));
    return 13'd1023;
  endfunction

  // one cycle with any mix of channels; called at a falling edge
  task automatic cyc(input string tag,
                     input logic cV, input logic [2:0] cC, input logic cF, input logic [31:0] cD,
                     input logic bV, input logic [2:0] bC, input logic bS, input logic [3:0] bI,
                     input logic [7:0] bB,
                     input logic aV, input logic [2:0] aC, input logic [3:0] aI);
    logic [7:0] tgt;
    logic [12:0] ea;
    logic [7:0] setV, clrV;
    cmdValid = cV; cmdCpu = cC; cmdFull = cF; cmdData = cD;
    byteValid = bV; byteCpu = bC; byteSet = bS; byteId = bI; byteBits = bB;
    ackValid = aV; ackCpu = aC; ackId = aI;
    #5;
    ea = expAck(aC, aI);
    if (aV) begin
      checks++;
      if (ackWord !== ea) begin
        failures++;
        $display("FAIL %s ackWord actual=%0d expected=%0d", tag, ackWord, ea);
      end
    end
    tgt = 8'h00;
    if (cV && cF && cC < NC) begin
      case (cD[25:24])
        2'd0: tgt = cD[23:16] & 8'h0F;
        2'd1: tgt = 8'h0F & ~(8'h01 << cC);
        2'd2: tgt = 8'h01 << cC;
        default: tgt = 8'h00;
      endcase
    end
    for (int i = 0; i < 16; i++) begin
      for (int t = 0; t < NC; t++) begin
        logic hitS, hitC;
        setV = 0; clrV = 0; hitS = 0; hitC = 0;
        if (tgt[t] && cD[3:0] == 4'(i)) begin setV |= 8'h01 << cC; hitS = 1; end
        if (bV && bC < NC && bC == 3'(t) && bI == 4'(i)) begin
          if (bS) begin setV |= bB & 8'h0F; hitS = 1; end
          else begin clrV |= bB & 8'h0F; hitC = 1; end
        end
        if (aV && ea != 13'd1023 && aC == 3'(t) && aI == 4'(i)) begin
          clrV |= 8'h01 << ea[12:10]; hitC = 1;
        end
        mMap[i][t] = (mMap[i][t] & ~clrV) | setV;
        if (hitS) mPend[i][t] = 1;
        else if (hitC && mMap[i][t] == 0) mPend[i][t] = 0;
      end
    end
    @(posedge clk); @(negedge clk);
    cmdValid = 0; byteValid = 0; ackValid = 0;
    checks++;
    if (pendOut !== expPend()) begin
      failures++;
      $display("FAIL %s pendOut actual=%h expected=%h", tag, pendOut, expPend());
    end
  endtask

  task automatic dispatch(input string tag, input logic [2:0] c, input logic f,
                          input logic [1:0] filt, input logic [7:0] lst, input logic [3:0] id);
    cyc(tag, 1, c, f, {6'd0, filt, lst, 12'hABC, id}, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic byteop(input string tag, input logic [2:0] c, input logic s,
                        input logic [3:0] id, input logic [7:0] b);
    cyc(tag, 0, 0, 0, 0, 1, c, s, id, b, 0, 0, 0);
  endtask

  task automatic ack(input string tag, input logic [2:0] c, input logic [3:0] id);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, c, id);
  endtask

  task automatic drainAll(input string tag);
    for (int t = 0; t < NC; t++)
      for (int i = 0; i < 16; i++)
        for (int k = 0; k < 5; k++) ack(tag, 3'(t), 4'(i));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++)
      for (int t = 0; t < 8; t++) begin mMap[i][t] = 0; mPend[i][t] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state
    checks++;
    if (pendOut !== '0) begin
      failures++;
      $display("FAIL R1 pendOut actual=%h expected=0", pendOut);
    end
    for (int i = 0; i < 16; i++) ack("R1 empty after reset", 3'(i % NC), 4'(i));

    // R2 R3 R4 R5: every sender with every filter, then lowest-first drain (R7 R8)
    for (int c = 0; c < NC; c++)
      for (int f = 0; f < 4; f++) begin
        dispatch(f == 0 ? "R2 list" : f == 1 ? "R3 others" : f == 2 ? "R4 self" : "R5 bad filter",
                 3'(c), 1, 2'(f), 8'hF0 | 8'(5 << c), 4'((c * 3 + f) % 16));
      end
    for (int c = 0; c < NC; c++) dispatch("R2 shared id", 3'(c), 1, 2'd0, 8'hFF, 4'd9);
    drainAll("R7 R8 drain lowest first");

    // R6: narrow writes ignored
    for (int f = 0; f < 3; f++) dispatch("R6 narrow", 3'(f), 0, 2'(f), 8'h0F, 4'd2);

    // R9: empty acknowledge after drain
    ack("R9 empty", 3'd1, 4'd9);

    // R10 R11: byte set then partial and full clear
    for (int c = 0; c < NC; c++) begin
      byteop("R11 set", 3'(c), 1, 4'(c + 4), 8'hFA);
      byteop("R10 clear part", 3'(c), 0, 4'(c + 4), 8'h02);
      ack("R7 after clear", 3'(c), 4'(c + 4));
      byteop("R10 clear rest", 3'(c), 0, 4'(c + 4), 8'hFF);
    end
    byteop("R11 set zero bits", 3'd2, 1, 4'd15, 8'h00);
    ack("R9 pending empty map", 3'd2, 4'd15);
    byteop("R10 clear empty", 3'd2, 0, 4'd15, 8'h00);

    // R12: processor index out of range
    dispatch("R12 cmd cpu", 3'd5, 1, 2'd2, 8'h0F, 4'd3);
    byteop("R12 byte cpu", 3'd6, 1, 4'd3, 8'h0F);
    ack("R12 ack cpu", 3'd7, 4'd3);

    // R13: same-cycle set and clear of one bit; set wins
    byteop("R13 prep", 3'd0, 1, 4'd5, 8'h02);
    cyc("R13 merge", 1, 3'd1, 1, {6'd0, 2'd0, 8'h01, 12'h000, 4'd5},
        1, 3'd0, 0, 4'd5, 8'h02, 1, 3'd0, 4'd5);
    ack("R13 bit kept", 3'd0, 4'd5);
    drainAll("R8 final drain");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule